// File: doc/BRIEF.md
# Configurable Cyclic Up/Down Counter with Compare and PWM

This block is a 10-bit cyclic counter that steps up or down once per count enable. The enable comes from one of eight sources chosen by a 3-bit select. Six of them are single-cycle taps from a prescaler chain that lives elsewhere. The other two are external event pins, which turn the block into an event counter. All control inputs are register-style levels, except `load_i`, which is a one-cycle command.

The register always counts on its full width. A length select shortens only the window that terminal-count detection looks at: the low 10, 8, 6 or 4 bits. A single data input has two jobs. It is the value a load copies into the counter, and it is the operand the comparator matches against. The comparator uses either all bits or only the selected low bits. Two interrupt request pulses, each gated by its own enable, and a PWM level are produced from the terminal and compare events.

Top module: `cyc_counter`

## Requirements
- R1: While `rst_i` is high at a clock edge, the count, both interrupt outputs and `pwm_o` become 0.
- R2: A step happens in a cycle where `run_i` is 1, the selected source enable is 1 and `load_i` is 0. On a step the count becomes count+1 when `up_i`=1 and count-1 when `up_i`=0, modulo 1024. The count therefore wraps 3FF→000 going up and 000→3FF going down, whatever the length select is.
- R3: When `load_i` is 1 at a clock edge, the count takes `data_i`. This applies regardless of `run_i` and of the source enable, so a load takes priority over a step.
- R4: The length select codes are 00 for 10 bits, 01 for 8, 10 for 6 and 11 for 4. A terminal event occurs on a step whose new count has its selected low bits all ones (counting up) or all zeros (counting down). It shows as a one-cycle `irq_tc_o` pulse in the same cycle the new count appears.
- R5: `src_sel_i` values 0 to 5 select `tap_i[0]` to `tap_i[5]`, which are used directly as count enables. Values 6 and 7 select `ext_i[0]` and `ext_i[1]`. These pins pass through a two-flop synchronizer, and each rising edge counts once. A rise present before clock edge E1 changes the count at edge E3, and a pin held high counts only once.
- R6: With `cmp_en_i`=1, a compare event occurs on a step whose new count equals `data_i`. The match covers all 10 bits when `cmp_full_i`=1, or only the bits selected by the length select when it is 0. The event shows as a one-cycle pulse on `irq_cmp_o`, aligned with the new count.
- R7: `irq_tc_o` pulses only when `irq_tc_en_i`=1, and `irq_cmp_o` pulses only when `irq_cmp_en_i`=1. An enable of 0 masks its request.
- R8: `pwm_o` is set by a terminal event and cleared by a compare event, with clear winning if both occur in the same step. It is forced low in any cycle after `run_i` was 0. The interrupt enables do not affect it.
- R9: With `load_i`=0, the count holds when `run_i` is 0 or the selected enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tap_i | input | 6 | Single-cycle prescaler count enables |
| ext_i | input | 2 | Asynchronous external event pins |
| src_sel_i | input | 3 | Count source select |
| up_i | input | 1 | 1 = count up, 0 = count down |
| run_i | input | 1 | Counting enabled |
| load_i | input | 1 | Copy `data_i` into the count |
| cmp_en_i | input | 1 | Compare detection enabled |
| len_sel_i | input | 2 | Terminal-count window length |
| cmp_full_i | input | 1 | 1 = compare all bits, 0 = selected window only |
| irq_tc_en_i | input | 1 | Terminal interrupt enable |
| irq_cmp_en_i | input | 1 | Compare interrupt enable |
| data_i | input | 10 | Load value and compare operand |
| count_o | output | 10 | Current count |
| irq_tc_o | output | 1 | Terminal-count request pulse |
| irq_cmp_o | output | 1 | Compare request pulse |
| pwm_o | output | 1 | PWM level |

## Verification
On every cycle, the assertions check that the count holds, loads or increments when it should. They also check that every interrupt pulse lands on a count whose windowed bits meet the terminal or compare condition, that PWM stays low after a stopped cycle, and that an external edge never lasts two cycles. Other properties can only be shown by the bench's scenarios. These are the exact three-edge latency of an external rise, the choice of window for each length code, the effect of masking, wrap-around in both directions, and the set/clear ordering of PWM across long random runs.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    WIN_10 = 2'b00,
    WIN_8  = 2'b01,
    WIN_6  = 2'b10,
    WIN_4  = 2'b11
  } win_e;
endpackage

// File: rtl/cc_src_mux.sv
module cc_src_mux #(
  parameter int NUM_TAPS = 6,
  parameter int NUM_EXT  = 2,
  parameter int SEL_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [NUM_EXT-1:0]  ext_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                tick_o
);
  logic [NUM_EXT-1:0] edge_w;

  for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= ext_i[k];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign edge_w[k] = sync_q & ~prev_q;

    // R5
    single_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      edge_w[k] |=> !edge_w[k]);
  end

  always_comb begin
    tick_o = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (int'(sel_i) == i) tick_o = tap_i[i];
    for (int k = 0; k < NUM_EXT; k++)
      if (int'(sel_i) == NUM_TAPS + k) tick_o = edge_w[k];
  end
endmodule

// File: rtl/cc_core.sv
module cc_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             load_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign step_o = run_i & tick_i & ~load_i;

  always_comb begin
    if (load_i)      next_o = data_i;
    else if (step_o) next_o = up_i ? count_o + ONE : count_o - ONE;
    else             next_o = count_o;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) count_o <= '0;
    else       count_o <= next_o;
  end

  // R3
  load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> count_o == $past(data_i));

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !(run_i && tick_i)) |=> $stable(count_o));

  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && tick_i && !load_i && up_i) |=> count_o == $past(count_o) + ONE);
endmodule

// File: rtl/cc_detect.sv
module cc_detect #(
  parameter int CNT_W = 10,
  parameter int LEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] next_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             up_i,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             cmp_en_i,
  input  logic             cmp_full_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             tc_en_i,
  input  logic             cmp_irq_en_i,
  output logic             irq_tc_o,
  output logic             irq_cmp_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] win_mask, cmp_mask;
  logic             tc_hit, cmp_hit;

  assign win_mask = ALL1 >> {len_i, 1'b0};
  assign cmp_mask = cmp_full_i ? ALL1 : win_mask;
  assign tc_hit   = step_i & ((next_i & win_mask) == (up_i ? win_mask : '0));
  assign cmp_hit  = step_i & cmp_en_i & (((next_i ^ data_i) & cmp_mask) == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_tc_o  <= 1'b0;
      irq_cmp_o <= 1'b0;
      pwm_o     <= 1'b0;
    end else begin
      irq_tc_o  <= tc_hit & tc_en_i;
      irq_cmp_o <= cmp_hit & cmp_irq_en_i;
      if (!run_i || cmp_hit) pwm_o <= 1'b0;
      else if (tc_hit)       pwm_o <= 1'b1;
    end
  end

  // R8
  pwm_stop_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> !pwm_o);

  // R4
  tc_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_tc_o |-> (count_i & $past(win_mask)) == $past(up_i ? win_mask : '0));

  // R6
  cmp_match_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_cmp_o |-> ((count_i ^ $past(data_i)) & $past(cmp_mask)) == '0);
endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int CNT_W    = 10,
  parameter int NUM_TAPS = 6,
  parameter int NUM_EXT  = 2,
  parameter int SEL_W    = 3,
  parameter int LEN_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic [NUM_EXT-1:0]  ext_i,
  input  logic [SEL_W-1:0]    src_sel_i,
  input  logic                up_i,
  input  logic                run_i,
  input  logic                load_i,
  input  logic                cmp_en_i,
  input  logic [LEN_W-1:0]    len_sel_i,
  input  logic                cmp_full_i,
  input  logic                irq_tc_en_i,
  input  logic                irq_cmp_en_i,
  input  logic [CNT_W-1:0]    data_i,
  output logic [CNT_W-1:0]    count_o,
  output logic                irq_tc_o,
  output logic                irq_cmp_o,
  output logic                pwm_o
);
  logic             tick_w, step_w;
  logic [CNT_W-1:0] next_w;

  cc_src_mux #(.NUM_TAPS(NUM_TAPS), .NUM_EXT(NUM_EXT), .SEL_W(SEL_W)) u_src (
    .clk_i(clk_i), .rst_i(rst_i), .tap_i(tap_i), .ext_i(ext_i),
    .sel_i(src_sel_i), .tick_o(tick_w)
  );

  cc_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_w), .run_i(run_i),
    .load_i(load_i), .up_i(up_i), .data_i(data_i),
    .count_o(count_o), .next_o(next_w), .step_o(step_w)
  );

  cc_detect #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_det (
    .clk_i(clk_i), .rst_i(rst_i), .step_i(step_w), .next_i(next_w),
    .count_i(count_o), .up_i(up_i), .run_i(run_i), .len_i(len_sel_i),
    .cmp_en_i(cmp_en_i), .cmp_full_i(cmp_full_i), .data_i(data_i),
    .tc_en_i(irq_tc_en_i), .cmp_irq_en_i(irq_cmp_en_i),
    .irq_tc_o(irq_tc_o), .irq_cmp_o(irq_cmp_o), .pwm_o(pwm_o)
  );
endmodule

// File: tb/cyc_counter_tb_top.sv
`timescale 1ns/1ps
module cyc_counter_tb_top;
  logic       clk = 1'b0, rst = 1'b1;
  logic [5:0] tap = '0;
  logic [1:0] ext = '0;
  logic [2:0] src_sel = 3'd5;
  logic       up = 1'b1, run = 1'b0, load = 1'b0, cmp_en = 1'b0;
  logic [1:0] len_sel = 2'b00;
  logic       cmp_full = 1'b1, tc_en = 1'b0, cmp_ien = 1'b0;
  logic [9:0] data = '0;
  logic [9:0] count;
  logic       irq_tc, irq_cmp, pwm;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_tc = 0, m_cmp = 0, m_pwm = 0;
  int e_s1[2] = '{0, 0}, e_s2[2] = '{0, 0}, e_pv[2] = '{0, 0};

  always #2 clk = ~clk;

  cyc_counter dut_i (
    .clk_i(clk), .rst_i(rst), .tap_i(tap), .ext_i(ext), .src_sel_i(src_sel),
    .up_i(up), .run_i(run), .load_i(load), .cmp_en_i(cmp_en),
    .len_sel_i(len_sel), .cmp_full_i(cmp_full), .irq_tc_en_i(tc_en),
    .irq_cmp_en_i(cmp_ien), .data_i(data), .count_o(count),
    .irq_tc_o(irq_tc), .irq_cmp_o(irq_cmp), .pwm_o(pwm)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_tc = 0; m_cmp = 0; m_pwm = 0;
      for (int k = 0; k < 2; k++) begin e_s1[k] = 0; e_s2[k] = 0; e_pv[k] = 0; end
    end else begin
      int tick, stp, nxt, win, tce, cme;
      tick = (src_sel < 6) ? int'(tap[src_sel]) : (e_s2[src_sel-6] & ~e_pv[src_sel-6] & 1);
      stp  = run && tick && !load;
      if (load)     nxt = data;
      else if (stp) nxt = up ? (m_cnt + 1) % 1024 : (m_cnt + 1023) % 1024;
      else          nxt = m_cnt;
      win = 1023 >> (2 * len_sel);
      tce = stp && (up ? ((nxt & win) == win) : ((nxt & win) == 0));
      cme = stp && cmp_en && (((nxt ^ data) & (cmp_full ? 1023 : win)) == 0);
      m_tc  = tce && tc_en;
      m_cmp = cme && cmp_ien;
      if (!run || cme) m_pwm = 0;
      else if (tce)    m_pwm = 1;
      m_cnt = nxt;
      for (int k = 0; k < 2; k++) begin
        e_pv[k] = e_s2[k]; e_s2[k] = e_s1[k]; e_s1[k] = ext[k];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 count vs model", count, m_cnt);
      chk("R4 irq_tc vs model", irq_tc, m_tc);
      chk("R6 irq_cmp vs model", irq_cmp, m_cmp);
      chk("R8 pwm vs model", pwm, m_pwm);
    end
  end

  task automatic nclk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    nclk(4);
    rst = 1'b0;
    nclk(1);
    chk("R1 reset count", count, 0);
    chk("R1 reset irq_tc", irq_tc, 0);
    chk("R1 reset pwm", pwm, 0);

    // load then count up through 3FF with 10-bit window
    tap = 6'h3F; src_sel = 3'd5; tc_en = 1; cmp_ien = 1;
    data = 10'h3FC; load = 1;
    nclk(1);
    chk("R3 load value", count, 10'h3FC);
    load = 0; run = 1;
    nclk(3);
    chk("R4 reach 3FF", count, 10'h3FF);
    chk("R4 tc pulse", irq_tc, 1);
    chk("R8 pwm set", pwm, 1);
    nclk(1);
    chk("R2 wrap up", count, 10'h000);
    chk("R4 tc one cycle", irq_tc, 0);

    // load wins over step
    data = 10'h005; load = 1;
    nclk(1);
    chk("R3 load priority", count, 10'h005);
    load = 0;

    // stopped holds count and forces pwm low
    run = 0;
    nclk(2);
    chk("R9 hold", count, 10'h005);
    chk("R8 pwm stopped", pwm, 0);

    // 4-bit window down count
    len_sel = 2'b11; up = 0; data = 10'h123; load = 1;
    nclk(1);
    load = 0; run = 1;
    nclk(3);
    chk("R4 4-bit window count", count, 10'h120);
    chk("R4 4-bit window tc", irq_tc, 1);

    // masked terminal request
    tc_en = 0; data = 10'h112; load = 1;
    nclk(1);
    load = 0;
    nclk(2);
    chk("R7 masked count", count, 10'h110);
    chk("R7 masked tc", irq_tc, 0);

    // truncated compare: low 4 bits 8 match while full value differs
    run = 0; up = 1; data = 10'h005; load = 1;
    nclk(1);
    load = 0; run = 1; cmp_en = 1; cmp_full = 0; data = 10'h3F8;
    nclk(3);
    chk("R6 truncated count", count, 10'h008);
    chk("R6 truncated cmp", irq_cmp, 1);

    // external event latency
    run = 0; cmp_en = 0; data = 10'h010; load = 1; src_sel = 3'd6; tap = '0;
    nclk(1);
    load = 0; run = 1;
    nclk(3);
    ext[0] = 1;
    nclk(1);
    chk("R5 ext edge1", count, 10'h010);
    nclk(1);
    chk("R5 ext edge2", count, 10'h010);
    nclk(1);
    chk("R5 ext edge3", count, 10'h011);
    nclk(3);
    chk("R5 ext held", count, 10'h011);

    // random traffic against the model
    tc_en = 1;
    for (int i = 0; i < 4000; i++) begin
      tap      = 6'($urandom);
      src_sel  = 3'($urandom);
      if ($urandom % 5 == 0) ext = 2'($urandom);
      run      = ($urandom % 16) != 0;
      load     = ($urandom % 40) == 0;
      up       = (i / 300) % 2 == 0;
      if ($urandom % 8 == 0) data = 10'($urandom);
      if (i % 64 == 0) begin
        len_sel  = 2'($urandom);
        cmp_full = 1'($urandom);
        cmp_en   = 1'($urandom);
        tc_en    = 1'($urandom);
        cmp_ien  = 1'($urandom);
      end
      nclk(1);
    end
    finish_run();
  end
endmodule